// File: doc/BRIEF.md
# Line-Doubling Video Converter with 18-bit Dithered Output

This block turns a progressive video stream at about 15 kHz line rate into one at about 30 kHz with the same field rate. Pixels arrive as 24-bit RGB, at most one every second clock. Each complete input line goes into one half of a two-line ping-pong buffer. While the next line fills the other half, the finished line is read out twice at one pixel per clock. Every source line therefore becomes two output lines, and the field rate stays at 50 or 60 Hz.

Each 8-bit channel is cut to 6 bits on the way out. Before the two low bits are dropped, a 2-bit threshold is added to the channel. That threshold combines three things: a 2x2 ordered pattern taken from the output pixel and line parity, a frame parity that flips every frame, and an optional bit from a free-running 16-bit LFSR. An optional scanline effect halves every channel of the second copy of each line.

The write side has two named states. W_WAIT moves to W_FILL on a pixel that marks the start of a line. W_FILL returns to W_WAIT on the last pixel of the line, and it stays in W_FILL and starts again at pixel 0 when a new line begins early. The read side has three named states. R_IDLE moves to R_PASS0 when a finished line is available. R_PASS0 moves to R_PASS1 after LINE_W pixels. After its LINE_W pixels, R_PASS1 moves to R_PASS0 if another line is waiting, and to R_IDLE if not.

Top module: `scandoubler_dither`

## Requirements
- R1: While reset is held and on the first cycle after it is released, out_valid, out_sol, out_sof and out_rgb are all zero.
- R2: A complete input line (LINE_W accepted pixels, the first with in_sol) produces two output lines of LINE_W pixels each, in input order. Each output line has one pixel per clock with no gaps. The first output pixel appears 3 clocks after the clock edge that sampled the last input pixel. When the next line completes in time, the pairs follow one another with no gap.
- R3: out_sol is high on the first pixel of every output line. out_sof is high only on the first pixel of the first copy of a line whose first input pixel carried in_sof.
- R4: out_rgb is {R[17:12], G[11:6], B[5:0]}, and the input is {R[23:16], G[15:8], B[7:0]}. Each output channel equals (c + t) >> 2, where c is the input channel and t is the threshold. The result saturates at 63 when c + t exceeds 255.
- R5: The threshold bits are t[1] = x0 ^ p ^ f and t[0] = p ^ n. Here x0 is the LSB of the pixel index within the line, p is 0 for the first copy and 1 for the second, f is the frame parity and n is the random bit.
- R6: The frame parity is 0 after reset. It inverts when the first copy of a frame-start line begins, before that line's pixels are output.
- R7: When rand_en is 0, n is 0. When rand_en is 1, n is bit 0 of a 16-bit LFSR that advances every clock and never reaches zero.
- R8: When scan_en is high, each channel of the second copy of a line is the dithered value shifted right by one bit.
- R9: A pixel with in_sol that arrives before the current line is complete discards the partial line and starts a new one at pixel 0. The discarded line produces no output.
- R10: A pixel with in_valid that arrives outside a line (no in_sol while waiting for a line start) is ignored.
- R11: out_rgb is zero on every cycle where out_valid is low.
- R12: The buffer half being read is never the half being written while both sides are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the output pixel rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel strobe, at most every second clock |
| in_sol | input | 1 | Marks the first pixel of an input line |
| in_sof | input | 1 | With in_sol, marks the first line of a frame |
| in_rgb | input | 24 | Input pixel {R,G,B}, 8 bits each |
| scan_en | input | 1 | Darken the second copy of each line |
| rand_en | input | 1 | Add the LFSR bit to the threshold |
| out_valid | output | 1 | Output pixel valid |
| out_sol | output | 1 | First pixel of an output line |
| out_sof | output | 1 | First pixel of the first output line of a frame |
| out_rgb | output | 18 | Output pixel {R,G,B}, 6 bits each |

## Verification
The assertions assume that input pixels come no closer than every second clock. They also assume that no line finishes while two earlier lines are still waiting to be read, since only then does the ping-pong bank rule hold. The scanline check also assumes scan_en stays steady while a line is being output. The stimulus spaces pixels exactly two clocks apart, with lines back to back or separated by blanking gaps. It changes scan_en and rand_en only during gaps long enough for the output to drain.

// File: rtl/sd_pkg.sv
package sd_pkg;

    typedef enum logic [0:0] {
        W_WAIT,
        W_FILL
    } wr_state_t;

    typedef enum logic [1:0] {
        R_IDLE,
        R_PASS0,
        R_PASS1
    } rd_state_t;

    localparam int IN_CH_W  = 8;
    localparam int OUT_CH_W = 6;
    localparam int N_CH     = 3;

    // add a 2-bit threshold, drop two LSBs, clamp at the channel maximum
    function automatic logic [OUT_CH_W-1:0] quant_ch(
        input logic [IN_CH_W-1:0] c,
        input logic [1:0]         t
    );
        logic [IN_CH_W:0] s;
        s = {1'b0, c} + {{(IN_CH_W-1){1'b0}}, t};
        return s[IN_CH_W] ? {OUT_CH_W{1'b1}} : s[IN_CH_W-1:2];
    endfunction

endpackage

// File: rtl/sd_line_writer.sv
module sd_line_writer
    import sd_pkg::*;
#(
    parameter int LINE_W = 320,
    parameter int AW     = $clog2(LINE_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sol,
    input  logic          in_sof,
    output logic          wr_en,
    output logic          wr_bank,
    output logic [AW-1:0] wr_addr,
    output logic          wr_active,
    output logic          line_done,
    output logic          done_bank,
    output logic          done_sof
);

    localparam logic [AW-1:0] LAST = AW'(LINE_W - 1);

    wr_state_t     state, state_nx;
    logic [AW-1:0] wcnt;
    logic          bank_q;
    logic          sof_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= W_WAIT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            W_WAIT: if (in_valid && in_sol) state_nx = W_FILL;
            W_FILL: if (in_valid && !in_sol && wcnt == LAST) state_nx = W_WAIT;
            default: state_nx = W_WAIT;
        endcase
    end

    assign wr_en     = in_valid && (in_sol || state == W_FILL);
    assign wr_addr   = in_sol ? '0 : wcnt;
    assign wr_bank   = bank_q;
    assign wr_active = (state == W_FILL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt      <= '0;
            bank_q    <= 1'b0;
            sof_q     <= 1'b0;
            line_done <= 1'b0;
            done_bank <= 1'b0;
            done_sof  <= 1'b0;
        end else begin
            line_done <= 1'b0;
            if (in_valid && in_sol) begin
                wcnt  <= AW'(1);
                sof_q <= in_sof;
            end else if (in_valid && state == W_FILL) begin
                if (wcnt == LAST) begin
                    line_done <= 1'b1;
                    done_bank <= bank_q;
                    done_sof  <= sof_q;
                    bank_q    <= ~bank_q;
                    wcnt      <= '0;
                end else begin
                    wcnt <= wcnt + AW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/sd_line_reader.sv
module sd_line_reader
    import sd_pkg::*;
#(
    parameter int LINE_W = 320,
    parameter int AW     = $clog2(LINE_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_done,
    input  logic          done_bank,
    input  logic          done_sof,
    output logic          rd_active,
    output logic          rd_bank,
    output logic [AW-1:0] rd_addr,
    output logic          rd_pass,
    output logic          rd_sol,
    output logic          rd_sof,
    output logic          rd_x0,
    output logic          frame_par
);

    localparam logic [AW-1:0] LAST = AW'(LINE_W - 1);

    rd_state_t     state, state_nx;
    logic [AW-1:0] rcnt;
    logic          bank_q, sof_q;
    logic          pend, pend_bank, pend_sof;
    logic          start, at_last, load, src_bank, src_sof;

    assign start    = line_done || pend;
    assign at_last  = (rcnt == LAST);
    assign load     = start && (state == R_IDLE || (state == R_PASS1 && at_last));
    assign src_bank = pend ? pend_bank : done_bank;
    assign src_sof  = pend ? pend_sof  : done_sof;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= R_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            R_IDLE:  if (start)   state_nx = R_PASS0;
            R_PASS0: if (at_last) state_nx = R_PASS1;
            R_PASS1: if (at_last) state_nx = start ? R_PASS0 : R_IDLE;
            default: state_nx = R_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcnt      <= '0;
            bank_q    <= 1'b0;
            sof_q     <= 1'b0;
            pend      <= 1'b0;
            pend_bank <= 1'b0;
            pend_sof  <= 1'b0;
            frame_par <= 1'b0;
        end else begin
            if (load) begin
                rcnt   <= '0;
                bank_q <= src_bank;
                sof_q  <= src_sof;
                if (src_sof) frame_par <= ~frame_par;
                pend   <= pend && line_done;
            end else begin
                if (state != R_IDLE) rcnt <= at_last ? '0 : rcnt + AW'(1);
                if (line_done) pend <= 1'b1;
            end
            if (line_done && (pend || !load)) begin
                pend_bank <= done_bank;
                pend_sof  <= done_sof;
            end
        end
    end

    assign rd_active = (state != R_IDLE);
    assign rd_bank   = bank_q;
    assign rd_addr   = rcnt;
    assign rd_pass   = (state == R_PASS1);
    assign rd_sol    = (rcnt == '0);
    assign rd_sof    = sof_q && (rcnt == '0) && (state == R_PASS0);
    assign rd_x0     = rcnt[0];

endmodule

// File: rtl/sd_linebuf.sv
module sd_linebuf #(
    parameter int LINE_W = 320,
    parameter int AW     = $clog2(LINE_W),
    parameter int DW     = 24
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [2][LINE_W];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_bank][wr_addr] <= wr_data;
        rd_data <= mem[rd_bank][rd_addr];
    end

endmodule

// File: rtl/sd_dither.sv
module sd_dither
    import sd_pkg::*;
#(
    parameter logic [15:0] LFSR_SEED = 16'hACE1,
    parameter logic [15:0] LFSR_TAPS = 16'hB400,
    localparam int IW = N_CH * IN_CH_W,
    localparam int OW = N_CH * OUT_CH_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_valid,
    input  logic [IW-1:0] s_rgb,
    input  logic          s_x0,
    input  logic          s_pass,
    input  logic          s_sol,
    input  logic          s_sof,
    input  logic          s_frame,
    input  logic          rand_en,
    input  logic          scan_en,
    output logic          out_valid,
    output logic          out_sol,
    output logic          out_sof,
    output logic [OW-1:0] out_rgb,
    output logic          out_pass,
    output logic [15:0]   lfsr
);

    logic [1:0]    thr;
    logic [OW-1:0] q;

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr <= LFSR_SEED;
        else        lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? LFSR_TAPS : 16'h0);
    end

    assign thr = {s_x0 ^ s_pass ^ s_frame, s_pass ^ (rand_en & lfsr[0])};

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic [OUT_CH_W-1:0] d;
        assign d = quant_ch(s_rgb[ch*IN_CH_W +: IN_CH_W], thr);
        assign q[ch*OUT_CH_W +: OUT_CH_W] = (scan_en && s_pass) ? (d >> 1) : d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sol   <= 1'b0;
            out_sof   <= 1'b0;
            out_rgb   <= '0;
            out_pass  <= 1'b0;
        end else begin
            out_valid <= s_valid;
            out_sol   <= s_valid && s_sol;
            out_sof   <= s_valid && s_sof;
            out_rgb   <= s_valid ? q : '0;
            out_pass  <= s_valid && s_pass;
        end
    end

endmodule

// File: rtl/scandoubler_dither.sv
module scandoubler_dither
    import sd_pkg::*;
#(
    parameter int LINE_W = 320,
    localparam int AW = $clog2(LINE_W),
    localparam int IW = N_CH * IN_CH_W,
    localparam int OW = N_CH * OUT_CH_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sol,
    input  logic          in_sof,
    input  logic [IW-1:0] in_rgb,
    input  logic          scan_en,
    input  logic          rand_en,
    output logic          out_valid,
    output logic          out_sol,
    output logic          out_sof,
    output logic [OW-1:0] out_rgb
);

    logic          wr_en, wr_bank, wr_active;
    logic [AW-1:0] wr_addr;
    logic          line_done, done_bank, done_sof;
    logic          rd_active, rd_bank, rd_pass, rd_sol, rd_sof, rd_x0, frame_par;
    logic [AW-1:0] rd_addr;
    logic [IW-1:0] rd_data;
    logic          s1_valid, s1_x0, s1_pass, s1_sol, s1_sof, s1_frame;
    logic          out_pass;
    logic [15:0]   lfsr;

    sd_line_writer #(.LINE_W(LINE_W), .AW(AW)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sol(in_sol), .in_sof(in_sof),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
        .wr_active(wr_active),
        .line_done(line_done), .done_bank(done_bank), .done_sof(done_sof)
    );

    sd_linebuf #(.LINE_W(LINE_W), .AW(AW), .DW(IW)) u_buf (
        .clk(clk),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(in_rgb),
        .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    sd_line_reader #(.LINE_W(LINE_W), .AW(AW)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .line_done(line_done), .done_bank(done_bank), .done_sof(done_sof),
        .rd_active(rd_active), .rd_bank(rd_bank), .rd_addr(rd_addr),
        .rd_pass(rd_pass), .rd_sol(rd_sol), .rd_sof(rd_sof),
        .rd_x0(rd_x0), .frame_par(frame_par)
    );

    // metadata travels alongside the synchronous buffer read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_x0    <= 1'b0;
            s1_pass  <= 1'b0;
            s1_sol   <= 1'b0;
            s1_sof   <= 1'b0;
            s1_frame <= 1'b0;
        end else begin
            s1_valid <= rd_active;
            s1_x0    <= rd_x0;
            s1_pass  <= rd_pass;
            s1_sol   <= rd_active && rd_sol;
            s1_sof   <= rd_active && rd_sof;
            s1_frame <= frame_par;
        end
    end

    sd_dither u_dith (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s1_valid), .s_rgb(rd_data), .s_x0(s1_x0), .s_pass(s1_pass),
        .s_sol(s1_sol), .s_sof(s1_sof), .s_frame(s1_frame),
        .rand_en(rand_en), .scan_en(scan_en),
        .out_valid(out_valid), .out_sol(out_sol), .out_sof(out_sof),
        .out_rgb(out_rgb), .out_pass(out_pass), .lfsr(lfsr)
    );

endmodule

// File: rtl/sd_checker.sv
module sd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        out_valid,
    input logic        out_sol,
    input logic        out_sof,
    input logic [17:0] out_rgb,
    input logic        out_pass,
    input logic        scan_en,
    input logic        rd_active,
    input logic        rd_bank,
    input logic        wr_active,
    input logic        wr_bank,
    input logic [15:0] lfsr
);

    // R3
    sol_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sol |-> out_valid);

    // R3
    sof_sol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_sol);

    // R2
    line_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_sol);

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_rgb == 18'd0);

    // R8
    scan_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_pass && $past(scan_en))
            |-> (!out_rgb[17] && !out_rgb[11] && !out_rgb[5]));

    // R12
    bank_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && wr_active) |-> rd_bank != wr_bank);

    // R7
    lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != 16'd0);

endmodule

bind scandoubler_dither sd_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .out_valid(out_valid), .out_sol(out_sol), .out_sof(out_sof),
    .out_rgb(out_rgb), .out_pass(out_pass), .scan_en(scan_en),
    .rd_active(rd_active), .rd_bank(rd_bank),
    .wr_active(wr_active), .wr_bank(wr_bank), .lfsr(lfsr)
);

// File: tb/scandoubler_dither_tb.sv
module scandoubler_dither_tb;

    localparam int LW = 8;

    typedef struct packed {
        logic [17:0] v0;
        logic [17:0] v1;
        logic        rnd;
        logic        sol;
        logic        sof;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0;
    logic [23:0] in_rgb = '0;
    logic        scan_en = 1'b0, rand_en = 1'b0;
    logic        out_valid, out_sol, out_sof;
    logic [17:0] out_rgb;

    int   checks = 0, fails = 0;
    int   cyc = 0;
    exp_t expq[$];
    bit   fpar = 1'b0;
    int   line_left = 0;
    int   last_cyc = 0;
    int   first_out_cyc = -1;
    bit   mon_on = 1'b0;
    logic [23:0] pix [LW];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    scandoubler_dither #(.LINE_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sol(in_sol), .in_sof(in_sof), .in_rgb(in_rgb),
        .scan_en(scan_en), .rand_en(rand_en),
        .out_valid(out_valid), .out_sol(out_sol), .out_sof(out_sof),
        .out_rgb(out_rgb)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] q6(input logic [7:0] c, input logic [1:0] t);
        int s;
        s = (int'(c) + int'(t)) >> 2;
        return (s > 63) ? 6'd63 : 6'(s);
    endfunction

    // R4 R5 R8: expected output for one pixel
    function automatic logic [17:0] exp_pix(input logic [23:0] p, input int x,
                                           input bit pass, input bit f,
                                           input bit n, input bit scan);
        logic [1:0]  t;
        logic [17:0] r;
        t = {x[0] ^ pass ^ f, pass ^ n};
        for (int ch = 0; ch < 3; ch++) begin
            logic [5:0] v;
            v = q6(p[ch*8 +: 8], t);
            if (scan && pass) v = v >> 1;
            r[ch*6 +: 6] = v;
        end
        return r;
    endfunction

    function automatic void push_line(input bit sof);
        exp_t e;
        if (sof) fpar = ~fpar;  // R6
        for (int p = 0; p < 2; p++)
            for (int x = 0; x < LW; x++) begin
                e.v0  = exp_pix(pix[x], x, p[0], fpar, 1'b0, scan_en);
                e.v1  = exp_pix(pix[x], x, p[0], fpar, 1'b1, scan_en);
                e.rnd = rand_en;
                e.sol = (x == 0);
                e.sof = (x == 0) && (p == 0) && sof;
                expq.push_back(e);
            end
    endfunction

    task automatic drive_pix(input logic [23:0] v, input bit sol, input bit sof);
        @(negedge clk);
        in_valid = 1'b1; in_sol = sol; in_sof = sof; in_rgb = v;
        last_cyc = cyc + 1;
        @(negedge clk);
        in_valid = 1'b0; in_sol = 1'b0; in_sof = 1'b0; in_rgb = '0;
    endtask

    task automatic send_line(input bit sof);
        for (int x = 0; x < LW; x++) drive_pix(pix[x], x == 0, sof && x == 0);
        push_line(sof);
    endtask

    task automatic fill_random();
        for (int x = 0; x < LW; x++) pix[x] = 24'($urandom);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // output monitor, samples away from the active edge
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (first_out_cyc < 0) first_out_cyc = cyc;
                if (expq.size() == 0) begin
                    check(1'b0, "R10/R9 unexpected output", 32'(out_rgb), 32'h0);
                end else begin
                    exp_t e;
                    bit ok;
                    e = expq.pop_front();
                    ok = (out_rgb == e.v0) || (e.rnd && out_rgb == e.v1);
                    check(ok, e.rnd ? "R7 random dither pixel" : "R4 R5 dither pixel",
                          32'(out_rgb), 32'(e.v0));
                    check(out_sol == e.sol, "R3 out_sol", 32'(out_sol), 32'(e.sol));
                    check(out_sof == e.sof, "R3 out_sof", 32'(out_sof), 32'(e.sof));
                    if (e.sol) line_left = LW - 1;
                    else if (line_left > 0) line_left--;
                end
            end else begin
                if (line_left > 0) begin
                    check(1'b0, "R2 gap inside output line", 32'(line_left), 32'h0);
                    line_left = 0;
                end
                if (out_rgb != '0)
                    check(1'b0, "R11 idle output nonzero", 32'(out_rgb), 32'h0);
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_rgb == '0, "R1 in reset",
              {13'd0, out_valid, out_rgb}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_sol == 1'b0 && out_sof == 1'b0 && out_rgb == '0,
              "R1 after reset", {11'd0, out_valid, out_sol, out_sof, out_rgb}, 32'h0);
        mon_on = 1'b1;

        // R2 latency and R4 saturation corner values
        pix[0] = 24'hFFFFFF; pix[1] = 24'h000000; pix[2] = 24'hFEFDFC;
        pix[3] = 24'hFFFEFD; pix[4] = 24'h030201; pix[5] = 24'h7F807F;
        pix[6] = 24'hFDFDFD; pix[7] = 24'hFCFCFC;
        send_line(1'b1);
        idle(40);
        check(first_out_cyc == last_cyc + 3, "R2 latency",
              32'(first_out_cyc), 32'(last_cyc + 3));
        check(expq.size() == 0, "R2 both copies drained", 32'(expq.size()), 32'h0);

        // R2 R6: back-to-back frame of random lines
        for (int l = 0; l < 6; l++) begin fill_random(); send_line(l == 0); end
        idle(40);
        check(expq.size() == 0, "R2 frame drained", 32'(expq.size()), 32'h0);

        // R6 second frame, R8 scanlines
        scan_en = 1'b1;
        for (int l = 0; l < 4; l++) begin fill_random(); send_line(l == 0); end
        idle(40);
        scan_en = 1'b0;

        // R7 random component
        rand_en = 1'b1;
        for (int l = 0; l < 4; l++) begin fill_random(); send_line(l == 0); end
        idle(40);
        rand_en = 1'b0;

        // R9: partial line abandoned by an early line start
        fill_random();
        drive_pix(24'h123456, 1'b1, 1'b0);
        drive_pix(24'h654321, 1'b0, 1'b0);
        drive_pix(24'hABCDEF, 1'b0, 1'b0);
        send_line(1'b0);
        idle(40);
        check(expq.size() == 0, "R9 restarted line output", 32'(expq.size()), 32'h0);

        // R10: stray pixels outside a line have no effect
        drive_pix(24'hFFFFFF, 1'b0, 1'b0);
        drive_pix(24'h808080, 1'b0, 1'b1);
        idle(40);
        check(expq.size() == 0 && !out_valid, "R10 stray pixels ignored",
              32'(out_valid), 32'h0);
        fill_random(); send_line(1'b0);
        idle(40);

        // R6: scanline mix with a new frame, stray pixel between lines
        scan_en = 1'b1;
        fill_random(); send_line(1'b1);
        drive_pix(24'h0F0F0F, 1'b0, 1'b0);
        fill_random(); send_line(1'b0);
        idle(40);
        scan_en = 1'b0;

        check(expq.size() == 0, "R2 all expected lines seen", 32'(expq.size()), 32'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule